// File: doc/BRIEF.md
# Four-Way Interleaved Word Memory Controller

This block sits in front of four word-wide storage modules and makes them look like one flat, word-addressed memory to a single requester. The low bits of each word address choose the module. The rest of the bits pick the word inside that module. As a result, consecutive word addresses land in different modules.

After a module has served an access, it needs a short recovery period before it can take another one. The controller keeps a separate countdown for each module. A request to a module that is free can proceed while other modules are still recovering. A request to a module that is recovering is held off by dropping the ready signal. A sequential stream therefore runs at one word per cycle, while repeated hits to one module are paced by its recovery time.

Reads complete with a fixed latency of one cycle and come back in request order. Each accepted read produces exactly one valid pulse. Writes produce no response.

Top module: `ilv_memctl`

## Requirements
- R1: Word address bits [1:0] select the module (0 to 3), and bits [ADDR_W-1:2] select the word inside it, so every word address names its own storage location.
- R2: An accepted read (reqValid, reqReady and reqWrite low at a rising edge) raises rdValid for exactly one cycle after that edge, with rdData equal to the word last written to that address; rdValid is never raised otherwise.
- R3: After a module accepts a request, reqReady is low for any address that maps to that module during the next RECOVER cycles (default 3).
- R4: reqReady is high whenever the addressed module has no recovery in progress, regardless of the state of the other modules.
- R5: An accepted write (reqWrite high) stores reqData at the addressed word and produces no rdValid pulse.
- R6: After reset, reqReady is high for every address and rdValid is low.
- R7: A stream of consecutive word addresses, reads or writes, is accepted at one request per cycle.
- R8: A stream of requests that all map to one module is accepted once every RECOVER+1 cycles.
- R9: A request held on a recovering module is accepted on the first cycle that its module becomes free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | ADDR_W | Word address of the request |
| reqData | input | DATA_W | Write data |
| reqReady | output | 1 | Addressed module can take the request this cycle |
| rdValid | output | 1 | Read data valid, one cycle after an accepted read |
| rdData | output | DATA_W | Read data |

## Verification
The assertions assume the following about the inputs:
- reqValid, reqWrite and reqAddr are known at every rising edge once reset is released.
- reqValid is held low while rstN is low, so no response can appear for a request that was made during reset.

The checker keeps its own count of cycles since each module was last used, and from it judges whether ready should be low or high. The bench follows these rules: it changes inputs only on falling edges, keeps reqValid low throughout reset, and fills every word before it reads anything, so every expected read value is defined.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Strobes passed from the control to the datapath for one cycle
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } ilvStrobe_t;

endpackage

// File: rtl/ilv_control.sv
module ilv_control
  import ilv_pkg::*;
#(
  parameter int NUM_MODS = 4,
  parameter int ADDR_W   = 6,
  parameter int RECOVER  = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic                        reqWrite,
  input  logic [ADDR_W-1:0]           reqAddr,
  output logic                        reqReady,
  output logic [$clog2(NUM_MODS)-1:0] bankSel,
  output ilvStrobe_t                  strobe
);
  localparam int SEL_W = $clog2(NUM_MODS);
  localparam int CNT_W = $clog2(RECOVER + 1) + 1;

  logic [CNT_W-1:0]    holdCnt [NUM_MODS];
  logic [NUM_MODS-1:0] bankBusy;
  logic                fire;

  // Module select: low word-address bits
  assign bankSel  = reqAddr[SEL_W-1:0];
  assign reqReady = !bankBusy[bankSel];
  assign fire     = reqValid && reqReady;

  always_comb begin
    strobe.wrEn = fire && reqWrite;
    strobe.rdEn = fire && !reqWrite;
  end

  always_comb begin
    for (int i = 0; i < NUM_MODS; i++) begin
      bankBusy[i] = (holdCnt[i] != '0);
    end
  end

  // One recovery countdown per module: loaded on use, runs down to zero
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_MODS; i++) holdCnt[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_MODS; i++) begin
        if (fire && bankSel == SEL_W'(i)) begin
          holdCnt[i] <= CNT_W'(RECOVER);
        end else if (holdCnt[i] != '0) begin
          holdCnt[i] <= holdCnt[i] - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ilv_datapath.sv
module ilv_datapath
  import ilv_pkg::*;
#(
  parameter int NUM_MODS = 4,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ilvStrobe_t                  strobe,
  input  logic [$clog2(NUM_MODS)-1:0] bankSel,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [DATA_W-1:0]           reqData,
  output logic                        rdValid,
  output logic [DATA_W-1:0]           rdData
);
  localparam int SEL_W = $clog2(NUM_MODS);
  localparam int IDX_W = ADDR_W - SEL_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0]  wordIdx;
  logic [DATA_W-1:0] bankQ [NUM_MODS];

  // Index inside a module: address with the select bits dropped
  assign wordIdx = reqAddr[ADDR_W-1:SEL_W];

  for (genvar g = 0; g < NUM_MODS; g++) begin : gBank
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (strobe.wrEn && bankSel == SEL_W'(g)) begin
        store[wordIdx] <= reqData;
      end
    end

    assign bankQ[g] = store[wordIdx];
  end

  // Fixed one-cycle read latency keeps responses in request order
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rdEn;
      if (strobe.rdEn) rdData <= bankQ[bankSel];
    end
  end

endmodule

// File: rtl/ilv_memctl.sv
module ilv_memctl
  import ilv_pkg::*;
#(
  parameter int NUM_MODS = 4,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int RECOVER  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              reqReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  localparam int SEL_W = $clog2(NUM_MODS);

  ilvStrobe_t       strobe;
  logic [SEL_W-1:0] bankSel;

  ilv_control #(
    .NUM_MODS(NUM_MODS), .ADDR_W(ADDR_W), .RECOVER(RECOVER)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqReady(reqReady), .bankSel(bankSel), .strobe(strobe)
  );

  ilv_datapath #(
    .NUM_MODS(NUM_MODS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bankSel(bankSel),
    .reqAddr(reqAddr), .reqData(reqData), .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: rtl/ilv_checker.sv
module ilv_checker #(
  parameter int NUM_MODS = 4,
  parameter int ADDR_W   = 6,
  parameter int RECOVER  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqReady,
  input logic              rdValid
);
  localparam int SEL_W = $clog2(NUM_MODS);
  localparam int AGE_W = $clog2(RECOVER + 2) + 1;
  localparam logic [AGE_W-1:0] FREE_AGE = AGE_W'(RECOVER + 1);

  logic [AGE_W-1:0] age [NUM_MODS];
  logic [SEL_W-1:0] sel;
  logic             accepted;
  logic             selFree;

  assign sel      = reqAddr[SEL_W-1:0];
  assign accepted = reqValid && reqReady;
  assign selFree  = (age[sel] == FREE_AGE);

  // Cycles since each module was last used, saturating once it is free
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_MODS; i++) age[i] <= FREE_AGE;
    end else begin
      for (int i = 0; i < NUM_MODS; i++) begin
        if (accepted && sel == SEL_W'(i)) age[i] <= AGE_W'(1);
        else if (age[i] != FREE_AGE)      age[i] <= age[i] + 1'b1;
      end
    end
  end

  AST_RECOVER_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    !selFree |-> !reqReady); // R3
  AST_FREE_READY: assert property (@(posedge clk) disable iff (!rstN)
    selFree |-> reqReady); // R4
  AST_READ_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !reqWrite) |=> rdValid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(accepted && !reqWrite)); // R2
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && reqWrite) |=> !rdValid); // R5

endmodule

bind ilv_memctl ilv_checker #(
  .NUM_MODS(NUM_MODS), .ADDR_W(ADDR_W), .RECOVER(RECOVER)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .reqReady(reqReady), .rdValid(rdValid)
);

// File: tb/ilv_memctl_tb.sv
module ilv_memctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 32;
  localparam int RECOVER = 3;
  localparam int WORDS   = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic              reqReady;
  logic              rdValid;
  logic [DATA_W-1:0] rdData;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  // Reference model state
  int                cyc = 0;
  int                lastAcc [4];
  logic [DATA_W-1:0] refMem [WORDS];
  logic [15:0]       lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_memctl #(.NUM_MODS(4), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RECOVER(RECOVER)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqData(reqData), .reqReady(reqReady), .rdValid(rdValid), .rdData(rdData)
  );

  task automatic check(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [DATA_W-1:0] pattern(input int i);
    return {8'hC3, 8'(i), 16'(i * 37 + 5)};
  endfunction

  // One cycle; entered right after a falling edge
  task automatic drive(input logic v, input logic w, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, output bit acc);
    bit                expReady;
    bit                pendRd;
    logic [DATA_W-1:0] pendData;
    reqValid = v; reqWrite = w; reqAddr = a; reqData = d;
    #1;
    expReady = (cyc - lastAcc[a[1:0]]) > RECOVER;
    check(reqReady == expReady, "R3 R4 ready", 32'(reqReady), 32'(expReady));
    acc = v && expReady;
    pendRd = 1'b0;
    pendData = '0;
    if (acc) begin
      lastAcc[a[1:0]] = cyc;
      if (w) refMem[a] = d;
      else begin
        pendRd = 1'b1;
        pendData = refMem[a];
      end
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
    check(rdValid == pendRd, "R2 R5 rdValid", 32'(rdValid), 32'(pendRd));
    if (pendRd) check(rdData == pendData, "R1 R2 rdData", rdData, pendData);
  endtask

  // Hold a request until accepted; returns cycles spent including the accepting one
  task automatic hold(input logic w, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                      output int spent);
    bit acc;
    spent = 0;
    acc = 1'b0;
    while (!acc) begin
      drive(1'b1, w, a, d, acc);
      spent++;
    end
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int k = 0; k < n; k++) drive(1'b0, 1'b0, '0, '0, acc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int spent;
    int total;
    int accN;
    bit acc;
    for (int b = 0; b < 4; b++) lastAcc[b] = -100;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;

    // R6: reset state
    check(rdValid == 1'b0, "R6 rdValid", 32'(rdValid), 32'd0);
    for (int b = 0; b < 4; b++) begin
      reqAddr = ADDR_W'(b);
      #1;
      check(reqReady == 1'b1, "R6 ready", 32'(reqReady), 32'd1);
    end
    @(negedge clk);

    // R7 and R5: sequential fill at one write per cycle, no responses
    total = 0;
    for (int i = 0; i < WORDS; i++) begin
      hold(1'b1, ADDR_W'(i), pattern(i), spent);
      total += spent;
    end
    check(total == WORDS, "R7 write stream cycles", 32'(total), 32'(WORDS));

    // R7 and R1: sequential read stream at one read per cycle
    accN = 0;
    for (int i = 0; i < 16; i++) begin
      drive(1'b1, 1'b0, ADDR_W'(i + 20), '0, acc);
      if (acc) accN++;
    end
    check(accN == 16, "R7 read stream accepts", 32'(accN), 32'd16);

    // R8: four reads to module 0 paced by recovery
    idle(2);
    total = 0;
    for (int i = 0; i < 4; i++) begin
      hold(1'b0, ADDR_W'(8 + 4 * ((i * 3) % 4)), '0, spent);
      total += spent;
    end
    check(total == 1 + 3 * (RECOVER + 1), "R8 same-module cycles",
          32'(total), 32'(1 + 3 * (RECOVER + 1)));

    // R9 and R5: write then read same word, stalled exactly until free
    idle(RECOVER + 1);
    hold(1'b1, ADDR_W'(5), 32'hDEAD_0005, spent);
    hold(1'b0, ADDR_W'(5), '0, spent);
    check(spent == RECOVER + 1, "R9 held read cycles", 32'(spent), 32'(RECOVER + 1));

    // R4: other module free while one recovers
    idle(RECOVER + 1);
    hold(1'b1, ADDR_W'(10), 32'h1234_000A, spent);
    drive(1'b1, 1'b0, ADDR_W'(11), '0, acc);
    check(acc == 1'b1, "R4 other module accepts", 32'(acc), 32'd1);

    // R1: neighbours of rewritten word keep their values
    idle(RECOVER + 1);
    hold(1'b0, ADDR_W'(1), '0, spent);
    hold(1'b0, ADDR_W'(9), '0, spent);
    hold(1'b0, ADDR_W'(13), '0, spent);

    // Mixed pseudo-random traffic against the model
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3], lfsr[9:4],
            {lfsr, lfsr ^ 16'h5A5A}, acc);
    end

    idle(2);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule